// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block is the address-recognition stage of a two-wire serial bus slave. A bit-level front end ahead of it turns the bus lines into three kinds of input: single-cycle START and STOP event strobes, a stream of complete bytes, and a level that marks the ninth clock of each byte, when an acknowledge may be driven. The matcher compares each address byte with a static own address, in either 7-bit or 10-bit mode. It decides whether to drive the acknowledge, and it reports whether the slave is selected and whether the master reads from it.

A START that arrives while the bus is busy is a repeated START. The block keeps what it needs across one, so that a 10-bit read header can follow a completed 10-bit write header. Reserved address groups are never acknowledged, and this includes the all-zero-plus-read pattern that masters send as a wake-up byte. Once the slave is selected it acknowledges every byte the master writes, and it stays silent on bytes the master reads.

The byte stream uses valid/ready. A byte is taken on a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` goes low on the cycle after a byte is taken and stays low until `ack_slot` falls. A sender that sees `byte_ready` low must hold `byte_valid` and `byte_data` until it rises. Bytes that arrive while the slave is idle or deselected are still taken and paced the same way, but they are never acknowledged.

Top module: `twi_addr_match`

## Requirements
- R1: A START strobe, whether the bus is free or busy, makes the next byte taken an address byte, even while a 10-bit header is only half complete.
- R2: In 7-bit mode (`cfg_ten_bit`=0), a first byte whose bits [7:1] equal `cfg_own_addr[6:0]` is acknowledged and sets `addressed`. `is_read` takes bit [0], where 1 means read.
- R3: In 7-bit mode, an address whose bits [6:3] are 0000 or 1111 is never acknowledged, even when it equals the own address. This covers byte 0x01 and the general call 0x00.
- R4: In 10-bit mode, a first byte with bits [7:3]=11110, bit [0]=0 and bits [2:1] equal to `cfg_own_addr[9:8]` is acknowledged, but `addressed` stays low until the second byte.
- R5: After such a header, a second byte equal to `cfg_own_addr[7:0]` is acknowledged, sets `addressed` with `is_read`=0, and is remembered as a completed 10-bit write match.
- R6: After a repeated START, a header of 11110 with matching bits [2:1] and bit [0]=1 is acknowledged and sets `addressed` with `is_read`=1, but only if the remembered match holds. Without it, the header is not acknowledged.
- R7: Bytes whose bits [7:3] are 11111 are not 10-bit headers. Any address byte that does not match is not acknowledged, clears `addressed`, `is_read` and the remembered match, and makes the block ignore bytes until the next START.
- R8: `addressed` and `is_read` hold across a repeated START until the next address byte decides them. A STOP clears both and the remembered match.
- R9: While the slave is addressed, every byte the master writes is acknowledged, and no byte is acknowledged while `is_read`=1.
- R10: `ack_drive` is high only while `ack_slot` is high, and only for a byte that was decided as acknowledged.
- R11: `byte_ready` is high after reset. It goes low on the cycle after a byte is taken and rises on the cycle after `ack_slot` falls.
- R12: `is_read` is high only while `addressed` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_own_addr | input | 10 | Own slave address; the low 7 bits are used in 7-bit mode |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit addressing |
| ev_start | input | 1 | One-cycle strobe for a START or repeated START |
| ev_stop | input | 1 | One-cycle strobe for a STOP; it wins when asserted together with `ev_start` |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| byte_ready | output | 1 | The block can take a byte |
| byte_data | input | 8 | Received byte, with the first bit on the bus in bit 7 |
| ack_slot | input | 1 | High during the ninth clock of the current byte |
| ack_drive | output | 1 | Pull the data line low to acknowledge |
| addressed | output | 1 | The slave is currently selected |
| is_read | output | 1 | The selected transfer is a master read |

## Verification
The bench uses the default widths: an 8-bit byte and a 10-bit own address, set to 0x2A5 so that the 7-bit address is 0x25 and the 10-bit upper pair is 10. It switches `cfg_ten_bit` between transfers, so one build reaches both the 7-bit matches and the two-byte header path, including a read header after a repeated START with and without a remembered match. It also moves the own address into the reserved groups, which shows that an exact match there is still refused.

// File: rtl/twi_am_pkg.sv
package twi_am_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int A7_W    = BYTE_W - 1;
  localparam int PFX_W   = BYTE_W - 1 - HI_W;
  localparam logic [PFX_W-1:0] HDR10_PFX = 5'b11110;
  localparam int RSV_W   = 4;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FIRST  = 3'd1,
    PH_SECOND = 3'd2,
    PH_DATA   = 3'd3,
    PH_SKIP   = 3'd4
  } am_phase_e;
endpackage

// File: rtl/twi_am_classify.sv
module twi_am_classify
  import twi_am_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] own_i,
  output logic          rw_o,
  output logic          hdr10_o,
  output logic          hi_ok_o,
  output logic          lo_ok_o,
  output logic          a7_ok_o
);
  localparam int L_A7  = BW - 1;
  localparam int L_HI  = AW - BW;
  localparam int L_PFX = BW - 1 - L_HI;
  localparam int N_RSV = 2;

  logic [L_A7-1:0] addr7;
  logic [N_RSV-1:0] rsv_hit;

  assign addr7 = byte_i[BW-1:1];
  assign rw_o  = byte_i[0];

  // One comparator per reserved group: all-zero and all-one top nibble.
  for (genvar g = 0; g < N_RSV; g++) begin : g_rsv
    localparam logic [RSV_W-1:0] GRP = (g == 0) ? '0 : '1;
    assign rsv_hit[g] = (addr7[L_A7-1 -: RSV_W] == GRP);
  end

  assign hdr10_o = (byte_i[BW-1 -: L_PFX] == HDR10_PFX);
  assign hi_ok_o = (byte_i[L_HI:1] == own_i[AW-1 -: L_HI]);
  assign lo_ok_o = (byte_i == own_i[BW-1:0]);
  assign a7_ok_o = (addr7 == own_i[L_A7-1:0]) && (rsv_hit == '0);
endmodule

// File: rtl/twi_am_ack_gate.sv
module twi_am_ack_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic take_i,
  input  logic decide_i,
  input  logic slot_i,
  output logic ready_o,
  output logic drive_o,
  output logic armed_o
);
  logic await_q;
  logic yes_q;
  logic slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_q <= 1'b0;
      yes_q   <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      slot_q <= slot_i;
      if (flush_i) begin
        await_q <= 1'b0;
        yes_q   <= 1'b0;
      end else if (take_i) begin
        await_q <= 1'b1;
        yes_q   <= decide_i;
      end else if (await_q && slot_q && !slot_i) begin
        await_q <= 1'b0;
        yes_q   <= 1'b0;
      end
    end
  end

  assign ready_o = !await_q;
  assign drive_o = await_q && yes_q && slot_i;
  assign armed_o = yes_q;
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match
  import twi_am_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_own_addr,
  input  logic          cfg_ten_bit,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          byte_valid,
  output logic          byte_ready,
  input  logic [BW-1:0] byte_data,
  input  logic          ack_slot,
  output logic          ack_drive,
  output logic          addressed,
  output logic          is_read
);
  am_phase_e phase_q;
  logic      addr_q, read_q, remember_q;
  logic      rw, hdr10, hi_ok, lo_ok, a7_ok;
  logic      take, decide, armed;

  twi_am_classify #(.BW(BW), .AW(AW)) u_cls (
    .byte_i  (byte_data),
    .own_i   (cfg_own_addr),
    .rw_o    (rw),
    .hdr10_o (hdr10),
    .hi_ok_o (hi_ok),
    .lo_ok_o (lo_ok),
    .a7_ok_o (a7_ok)
  );

  assign take = byte_valid && byte_ready && !ev_start && !ev_stop;

  always_comb begin
    decide = 1'b0;
    case (phase_q)
      PH_FIRST:  decide = cfg_ten_bit ? (hdr10 && hi_ok && (!rw || remember_q)) : a7_ok;
      PH_SECOND: decide = lo_ok;
      PH_DATA:   decide = !read_q;
      default:   decide = 1'b0;
    endcase
  end

  twi_am_ack_gate u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (ev_start || ev_stop),
    .take_i   (take),
    .decide_i (decide),
    .slot_i   (ack_slot),
    .ready_o  (byte_ready),
    .drive_o  (ack_drive),
    .armed_o  (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      addr_q     <= 1'b0;
      read_q     <= 1'b0;
      remember_q <= 1'b0;
    end else if (ev_stop) begin
      phase_q    <= PH_IDLE;
      addr_q     <= 1'b0;
      read_q     <= 1'b0;
      remember_q <= 1'b0;
    end else if (ev_start) begin
      phase_q <= PH_FIRST;
    end else if (take) begin
      case (phase_q)
        PH_FIRST: begin
          if (!cfg_ten_bit) begin
            if (a7_ok) begin
              addr_q  <= 1'b1;
              read_q  <= rw;
              phase_q <= PH_DATA;
            end else begin
              addr_q  <= 1'b0;
              read_q  <= 1'b0;
              phase_q <= PH_SKIP;
            end
          end else if (hdr10 && hi_ok && !rw) begin
            addr_q     <= 1'b0;
            read_q     <= 1'b0;
            remember_q <= 1'b0;
            phase_q    <= PH_SECOND;
          end else if (hdr10 && hi_ok && rw && remember_q) begin
            addr_q  <= 1'b1;
            read_q  <= 1'b1;
            phase_q <= PH_DATA;
          end else begin
            addr_q     <= 1'b0;
            read_q     <= 1'b0;
            remember_q <= 1'b0;
            phase_q    <= PH_SKIP;
          end
        end
        PH_SECOND: begin
          if (lo_ok) begin
            addr_q     <= 1'b1;
            read_q     <= 1'b0;
            remember_q <= 1'b1;
            phase_q    <= PH_DATA;
          end else begin
            addr_q     <= 1'b0;
            read_q     <= 1'b0;
            remember_q <= 1'b0;
            phase_q    <= PH_SKIP;
          end
        end
        default: phase_q <= phase_q;
      endcase
    end
  end

  assign addressed = addr_q;
  assign is_read   = read_q;

  logic unused_armed;
  assign unused_armed = armed;
endmodule

// File: rtl/twi_addr_match_chk.sv
module twi_addr_match_chk
  import twi_am_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       ack_slot,
  input logic       addressed,
  input logic       is_read,
  input am_phase_e  phase,
  input logic       armed
);
  logic took;
  assign took = byte_valid && byte_ready && !ev_start && !ev_stop;

  a_r1_start_expects_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_stop) |=> (phase == PH_FIRST));

  a_r2_select_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(byte_valid && byte_ready));

  a_r3_no_ack_wake_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (took && phase == PH_FIRST && byte_data == 8'h01) |=> !armed);

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!addressed && !is_read));

  a_r11_ready_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_ready && $fell(ack_slot) && !ev_start && !ev_stop) |=> byte_ready);

  a_r12_read_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |-> addressed);
endmodule

bind twi_addr_match twi_addr_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data),
  .ack_slot   (ack_slot),
  .addressed  (addressed),
  .is_read    (is_read),
  .phase      (phase_q),
  .armed      (armed)
);

// File: tb/twi_addr_match_tb_top.sv
module twi_addr_match_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_own_addr = 10'h2A5;
  logic       cfg_ten_bit = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ack_slot = 1'b0;
  logic       byte_ready, ack_drive, addressed, is_read;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  twi_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_own_addr(cfg_own_addr), .cfg_ten_bit(cfg_ten_bit),
    .ev_start(ev_start), .ev_stop(ev_stop), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .ack_slot(ack_slot), .ack_drive(ack_drive),
    .addressed(addressed), .is_read(is_read)
  );

  // {mode, pre(0 none,1 start,2 stop+start), byte, ack, addressed, is_read, req}
  localparam int NV = 18;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b0, 2'd2, 8'h4A, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 write select
    {1'b0, 2'd0, 8'h55, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 written data acked
    {1'b0, 2'd1, 8'h4B, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 read select after Sr
    {1'b0, 2'd0, 8'h77, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 read data not acked
    {1'b0, 2'd1, 8'h4C, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 other address
    {1'b0, 2'd0, 8'h4A, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ignored until START
    {1'b0, 2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 wake byte
    {1'b1, 2'd2, 8'hF4, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 header write
    {1'b1, 2'd0, 8'hA5, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 low byte
    {1'b1, 2'd0, 8'h12, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 data
    {1'b1, 2'd1, 8'hF5, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 read header remembered
    {1'b1, 2'd2, 8'hF5, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 after STOP: not remembered
    {1'b1, 2'd1, 8'hF4, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 header again
    {1'b1, 2'd0, 8'hA6, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 wrong low byte
    {1'b1, 2'd1, 8'hF5, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 no remembered match
    {1'b1, 2'd2, 8'hFC, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 11111 not a header
    {1'b1, 2'd2, 8'hF0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 upper pair mismatch
    {1'b1, 2'd2, 8'h4A, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 7-bit byte in 10-bit mode
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack, output logic rdy_mid,
                           output logic rdy_end);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0; rdy_mid = byte_ready; ack_slot = 1'b1;
    @(negedge clk); got_ack = ack_drive; ack_slot = 1'b0;
    @(negedge clk); rdy_end = byte_ready;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic a, rm, re;
    // Reset state, R11 and R10
    repeat (3) @(negedge clk);
    ack_slot = 1'b1;
    @(negedge clk);
    chk(10, "ack_drive in reset with slot high", ack_drive, 1'b0);
    chk(12, "is_read in reset", is_read, 1'b0);
    chk(8, "addressed in reset", addressed, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    ack_slot = 1'b0;
    chk(11, "byte_ready after reset", byte_ready, 1'b1);
    @(negedge clk);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      cfg_ten_bit = v[17];
      if (v[16:15] == 2'd2) pulse_stop();
      if (v[16:15] != 2'd0) pulse_start();
      send_byte(v[14:7], a, rm, re);
      chk(int'(v[3:0]), $sformatf("vec %0d ack", i), a, v[6]);
      chk(int'(v[3:0]), $sformatf("vec %0d addressed", i), addressed, v[5]);
      chk(int'(v[3:0]), $sformatf("vec %0d is_read", i), is_read, v[4]);
    end

    // R11 back-pressure around one byte
    cfg_ten_bit = 1'b0;
    pulse_stop(); pulse_start();
    send_byte(8'h4A, a, rm, re);
    chk(11, "byte_ready low while awaiting slot", rm, 1'b0);
    chk(11, "byte_ready back after slot falls", re, 1'b1);
    chk(2, "7-bit select ack", a, 1'b1);

    // R8 selection held across repeated START
    pulse_start();
    chk(8, "addressed held across Sr", addressed, 1'b1);
    send_byte(8'h4B, a, rm, re);
    chk(2, "read select ack", a, 1'b1);
    chk(12, "is_read after read select", is_read, 1'b1);
    pulse_stop();
    chk(8, "addressed after STOP", addressed, 1'b0);
    chk(8, "is_read after STOP", is_read, 1'b0);

    // R1 START in the middle of a 10-bit header restarts address decoding
    cfg_ten_bit = 1'b1;
    pulse_start();
    send_byte(8'hF4, a, rm, re);
    chk(4, "header ack before restart", a, 1'b1);
    pulse_start();
    send_byte(8'hA5, a, rm, re);
    chk(1, "low byte after Sr taken as address", a, 1'b0);
    chk(1, "addressed after misplaced low byte", addressed, 1'b0);

    // R3 own address inside reserved groups
    cfg_ten_bit = 1'b0;
    cfg_own_addr = 10'h078;
    pulse_stop(); pulse_start();
    send_byte(8'hF0, a, rm, re);
    chk(3, "own address 1111000 refused", a, 1'b0);
    cfg_own_addr = 10'h000;
    pulse_stop(); pulse_start();
    send_byte(8'h00, a, rm, re);
    chk(3, "general call refused", a, 1'b0);
    pulse_stop(); pulse_start();
    send_byte(8'h01, a, rm, re);
    chk(3, "wake byte refused", a, 1'b0);
    chk(3, "wake byte leaves deselected", addressed, 1'b0);
    cfg_own_addr = 10'h2A5;
    pulse_stop();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule